// File: doc/BRIEF.md
# Interrupt Vector Gate Dispatcher

This block sits between the interrupt sources of a core and its instruction fetch unit. It takes requests from external maskable lines, a non-maskable line, processor-detected exceptions and three software requests: an explicit vector instruction, a conditional overflow request and an invalid-opcode request. In an idle cycle it picks a single winner and resolves its vector. It then reads the 8-byte gate descriptor for that vector from a table in memory. The table's linear base and byte limit come from a 48-bit table register.

Once both descriptor words are back, the block validates the gate. On success it reports the handler selector and the 32-bit handler offset, the gate kind and the interrupt flag the handler must run with. It also reports the return address to save, chosen by the fault, trap or abort nature of the request. When a check fails, it reports a general-protection request on vector 13 instead. Stack pushes, task switching and segment translation are left to other logic.

Requests are sampled only while the block is idle. `busy` covers the whole dispatch, and `done` marks the single cycle in which the result outputs are fresh.

Top module: `ivd_dispatch`

## Requirements
- R1: When several requests are sampled together, only the highest one is dispatched, in this order: non-maskable, exception, explicit vector instruction, overflow request, invalid-opcode request, external maskable.
- R2: The vector is fixed by the source. The non-maskable request uses 2, a taken overflow request uses 4 and the invalid-opcode request uses 6. External requests use `irq_vec`, exceptions use `exc_vec` and the vector instruction uses `swi_vec`. An overflow request with `ovf_flag` = 0 is dropped: nothing is dispatched and `busy` stays low.
- R3: With `if_flag` = 0, an external maskable request is ignored and `busy` stays low. The non-maskable request and the explicit vector instruction are dispatched regardless of `if_flag`.
- R4: The descriptor is read as two 32-bit words: first at base + vector×8, then at that address + 4. `mem_rd` and `mem_addr` are held stable until `mem_valid` accepts each read.
- R5: On dispatch, `hnd_off` = {high word[31:16], low word[15:0]} and `hnd_sel` = low word[31:16].
- R6: A descriptor whose present bit (high word bit 15) is 0 is not dispatched and yields the general-protection outcome.
- R7: For the explicit vector instruction and the overflow request, dispatch needs `cpl` ≤ the descriptor privilege level (high word bits 14:13). Otherwise the general-protection outcome results. All other sources skip this check.
- R8: High word bits 12:8 give the gate type. 01110 is an interrupt gate, and `new_if` = 0. 01111 is a trap gate, and `new_if` = the sampled `if_flag`. `gate_trap` is 1 for a trap gate. Any other type yields the general-protection outcome.
- R9: If vector×8+7 exceeds the table limit (`tbl_reg[15:0]`), no memory read is issued and the general-protection outcome results.
- R10: The general-protection outcome sets `gp` = 1, `vec_out` = 13, `hnd_off` = 0, `hnd_sel` = 0, `gate_trap` = 0, `new_if` = the sampled `if_flag`, `ret_addr` = `cur_pc` and `ret_valid` = 1. A successful dispatch sets `gp` = 0 and `vec_out` to the chosen vector.
- R11: On dispatch, the return address follows the request class. Fault-class requests return `cur_pc`: invalid-opcode, non-maskable, external, and exceptions with `exc_kind` = 0. Trap-class requests return `next_pc`: the vector instruction, the overflow request, and exceptions with `exc_kind` = 1. Exceptions with `exc_kind` of 2 or 3 are aborts and give `ret_valid` = 0.
- R12: `busy` rises in the cycle after a request is accepted and stays high through `done`. `done` is a one-cycle pulse in the cycle after the second read is accepted. Requests presented while `busy` is high are ignored and not queued.
- R13: During and right after reset, `busy`, `done` and `mem_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_reg | input | BASE_W+LIMIT_W | Table register: base in upper bits, byte limit in lower LIMIT_W bits |
| if_flag | input | 1 | Current interrupt flag |
| cpl | input | 2 | Current privilege level |
| cur_pc | input | PC_W | Address of the current instruction |
| next_pc | input | PC_W | Address of the following instruction |
| nmi_req | input | 1 | Non-maskable request |
| exc_req | input | 1 | Processor-detected exception request |
| exc_kind | input | 2 | Exception class: 0 fault, 1 trap, 2 or 3 abort |
| exc_vec | input | 8 | Exception vector |
| swi_req | input | 1 | Explicit vector instruction request |
| swi_vec | input | 8 | Vector named by the instruction |
| ovf_req | input | 1 | Conditional overflow request |
| ovf_flag | input | 1 | Overflow status |
| ud_req | input | 1 | Invalid-opcode request |
| irq_req | input | 1 | External maskable request |
| irq_vec | input | 8 | External vector |
| mem_rd | output | 1 | Descriptor read request |
| mem_addr | output | BASE_W | Descriptor read address |
| mem_rdata | input | 32 | Read data |
| mem_valid | input | 1 | Read data valid; accepts the current read |
| busy | output | 1 | Dispatch in progress |
| done | output | 1 | One-cycle result pulse |
| gp | output | 1 | General-protection outcome |
| vec_out | output | 8 | Dispatched vector, or 13 |
| hnd_sel | output | 16 | Handler segment selector |
| hnd_off | output | 32 | Handler offset |
| gate_trap | output | 1 | 1 for trap gate, 0 for interrupt gate |
| new_if | output | 1 | Interrupt flag for the handler |
| ret_addr | output | PC_W | Return address to save |
| ret_valid | output | 1 | Return address is meaningful |

## Verification
The bench builds the block with its defaults: 32-bit base and program counter, a 16-bit limit and the limit check enabled. The table is placed at 0x10000. The limit is normally programmed to cover all 256 vectors and is then cut to 255 bytes, which brings the boundary between vectors 31 and 32 within reach. The bench's memory model answers every read one cycle late, so the hold of the read address and the timing of `done` relative to the second returned word are both observable.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
   localparam int VEC_W = 8;

   typedef enum logic [1:0] {
      RK_FAULT = 2'd0,
      RK_TRAP  = 2'd1,
      RK_ABORT = 2'd2
   } ret_kind_e;

   localparam logic [VEC_W-1:0] NMI_VEC = 8'd2;
   localparam logic [VEC_W-1:0] OVF_VEC = 8'd4;
   localparam logic [VEC_W-1:0] UD_VEC  = 8'd6;
   localparam logic [VEC_W-1:0] GP_VEC  = 8'd13;

   // bits 12:9 of the high word for a 32-bit interrupt or trap gate
   localparam logic [3:0] GATE32_TAG = 4'b0111;

   typedef struct packed {
      logic [VEC_W-1:0] vec;
      ret_kind_e        kind;
      logic             priv_chk;
   } pick_t;
endpackage

// File: rtl/ivd_arbiter.sv
module ivd_arbiter
   import ivd_pkg::*;
(
   input  logic             nmi_req,
   input  logic             exc_req,
   input  logic [1:0]       exc_kind,
   input  logic [VEC_W-1:0] exc_vec,
   input  logic             swi_req,
   input  logic [VEC_W-1:0] swi_vec,
   input  logic             ovf_req,
   input  logic             ovf_flag,
   input  logic             ud_req,
   input  logic             irq_req,
   input  logic [VEC_W-1:0] irq_vec,
   input  logic             if_flag,
   output logic             pick_vld,
   output pick_t            pick
);
   always_comb begin
      pick_vld      = 1'b1;
      pick.vec      = NMI_VEC;
      pick.kind     = RK_FAULT;
      pick.priv_chk = 1'b0;
      if (nmi_req) begin
         pick.vec = NMI_VEC;
      end else if (exc_req) begin
         pick.vec = exc_vec;
         case (exc_kind)
            2'd0:    pick.kind = RK_FAULT;
            2'd1:    pick.kind = RK_TRAP;
            default: pick.kind = RK_ABORT;
         endcase
      end else if (swi_req) begin
         pick.vec      = swi_vec;
         pick.kind     = RK_TRAP;
         pick.priv_chk = 1'b1;
      end else if (ovf_req && ovf_flag) begin
         pick.vec      = OVF_VEC;
         pick.kind     = RK_TRAP;
         pick.priv_chk = 1'b1;
      end else if (ud_req) begin
         pick.vec = UD_VEC;
      end else if (irq_req && if_flag) begin
         pick.vec = irq_vec;
      end else begin
         pick_vld = 1'b0;
      end
   end
endmodule

// File: rtl/ivd_fetch.sv
module ivd_fetch
   import ivd_pkg::*;
#(
   parameter int BASE_W      = 32,
   parameter int LIMIT_W     = 16,
   parameter bit LIMIT_CHECK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [VEC_W-1:0]   vec,
   input  logic [BASE_W-1:0]  base,
   input  logic [LIMIT_W-1:0] limit,
   output logic               mem_rd,
   output logic [BASE_W-1:0]  mem_addr,
   input  logic [31:0]        mem_rdata,
   input  logic               mem_valid,
   output logic [31:0]        lo_word,
   output logic               fin,
   output logic               bad,
   output logic               active
);
   localparam int OFS_W = VEC_W + 3;
   localparam int CMP_W = ((LIMIT_W > OFS_W) ? LIMIT_W : OFS_W) + 1;

   typedef enum logic [1:0] {F_IDLE, F_LO, F_HI, F_BAD} fstate_e;

   fstate_e           st;
   logic [BASE_W-1:0] addr_q;
   logic              in_range;
   logic [CMP_W-1:0]  end_off;

   assign end_off = CMP_W'({vec, 3'b111});

   generate
      if (LIMIT_CHECK) begin : g_lim
         assign in_range = (end_off <= CMP_W'(limit));
      end else begin : g_nolim
         assign in_range = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= F_IDLE;
         addr_q  <= '0;
         lo_word <= '0;
      end else begin
         case (st)
            F_IDLE: if (start) begin
               addr_q <= base + BASE_W'({vec, 3'b000});
               st     <= in_range ? F_LO : F_BAD;
            end
            F_LO: if (mem_valid) begin
               lo_word <= mem_rdata;
               st      <= F_HI;
            end
            F_HI: if (mem_valid) st <= F_IDLE;
            default: st <= F_IDLE;
         endcase
      end
   end

   assign mem_rd   = (st == F_LO) || (st == F_HI);
   assign mem_addr = (st == F_HI) ? addr_q + BASE_W'(4) : addr_q;
   assign fin      = ((st == F_HI) && mem_valid) || (st == F_BAD);
   assign bad      = (st == F_BAD);
   assign active   = (st != F_IDLE);

   // R4
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && !mem_valid |=> mem_rd && $stable(mem_addr));

   // R4
   word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == F_LO) && mem_valid |=> mem_rd && (mem_addr == $past(mem_addr) + BASE_W'(4)));

   // R9
   range_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !in_range |=> !mem_rd && fin);
endmodule

// File: rtl/ivd_gate_check.sv
module ivd_gate_check
   import ivd_pkg::*;
(
   input  logic [31:0] lo_word,
   input  logic [31:0] hi_word,
   input  logic [1:0]  cpl,
   input  logic        priv_chk,
   input  logic        if_in,
   output logic        ok,
   output logic        trap,
   output logic        new_if,
   output logic [15:0] sel,
   output logic [31:0] off
);
   logic       present;
   logic [1:0] dpl;
   logic       type_ok;
   logic       priv_ok;

   always_comb begin
      present = hi_word[15];
      dpl     = hi_word[14:13];
      type_ok = (hi_word[12:9] == GATE32_TAG);
      priv_ok = !priv_chk || (cpl <= dpl);
      ok      = present && type_ok && priv_ok;
      trap    = hi_word[8];
      new_if  = trap ? if_in : 1'b0;
      sel     = lo_word[31:16];
      off     = {hi_word[31:16], lo_word[15:0]};
   end
endmodule

// File: rtl/ivd_dispatch.sv
module ivd_dispatch
   import ivd_pkg::*;
#(
   parameter int BASE_W      = 32,
   parameter int LIMIT_W     = 16,
   parameter int PC_W        = 32,
   parameter bit LIMIT_CHECK = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [BASE_W+LIMIT_W-1:0] tbl_reg,
   input  logic                      if_flag,
   input  logic [1:0]                cpl,
   input  logic [PC_W-1:0]           cur_pc,
   input  logic [PC_W-1:0]           next_pc,
   input  logic                      nmi_req,
   input  logic                      exc_req,
   input  logic [1:0]                exc_kind,
   input  logic [VEC_W-1:0]          exc_vec,
   input  logic                      swi_req,
   input  logic [VEC_W-1:0]          swi_vec,
   input  logic                      ovf_req,
   input  logic                      ovf_flag,
   input  logic                      ud_req,
   input  logic                      irq_req,
   input  logic [VEC_W-1:0]          irq_vec,
   output logic                      mem_rd,
   output logic [BASE_W-1:0]         mem_addr,
   input  logic [31:0]               mem_rdata,
   input  logic                      mem_valid,
   output logic                      busy,
   output logic                      done,
   output logic                      gp,
   output logic [VEC_W-1:0]          vec_out,
   output logic [15:0]               hnd_sel,
   output logic [31:0]               hnd_off,
   output logic                      gate_trap,
   output logic                      new_if,
   output logic [PC_W-1:0]           ret_addr,
   output logic                      ret_valid
);
   localparam int TBL_W = BASE_W + LIMIT_W;

   if (BASE_W < 12) begin : g_bad_base
      $error("BASE_W must be at least 12");
   end
   if (LIMIT_W < 1 || PC_W < 1) begin : g_bad_width
      $error("LIMIT_W and PC_W must be positive");
   end

   logic             pick_vld;
   pick_t            pick;
   logic             accept;
   logic             f_active, f_fin, f_bad;
   logic [31:0]      lo_word;
   logic             done_q;
   ret_kind_e        kind_q;
   logic             priv_q, if_q;
   logic [1:0]       cpl_q;
   logic [PC_W-1:0]  cur_q, next_q;
   logic [VEC_W-1:0] vec_q;
   logic             c_ok, c_trap, c_newif;
   logic [15:0]      c_sel;
   logic [31:0]      c_off;

   assign busy   = f_active | done_q;
   assign accept = pick_vld & ~busy;
   assign done   = done_q;

   ivd_arbiter u_arb (
      .nmi_req (nmi_req),  .exc_req (exc_req),  .exc_kind (exc_kind),
      .exc_vec (exc_vec),  .swi_req (swi_req),  .swi_vec  (swi_vec),
      .ovf_req (ovf_req),  .ovf_flag(ovf_flag), .ud_req   (ud_req),
      .irq_req (irq_req),  .irq_vec (irq_vec),  .if_flag  (if_flag),
      .pick_vld(pick_vld), .pick    (pick)
   );

   ivd_fetch #(
      .BASE_W(BASE_W), .LIMIT_W(LIMIT_W), .LIMIT_CHECK(LIMIT_CHECK)
   ) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .vec      (pick.vec),
      .base     (tbl_reg[TBL_W-1:LIMIT_W]),
      .limit    (tbl_reg[LIMIT_W-1:0]),
      .mem_rd   (mem_rd),
      .mem_addr (mem_addr),
      .mem_rdata(mem_rdata),
      .mem_valid(mem_valid),
      .lo_word  (lo_word),
      .fin      (f_fin),
      .bad      (f_bad),
      .active   (f_active)
   );

   ivd_gate_check u_chk (
      .lo_word (lo_word),
      .hi_word (mem_rdata),
      .cpl     (cpl_q),
      .priv_chk(priv_q),
      .if_in   (if_q),
      .ok      (c_ok),
      .trap    (c_trap),
      .new_if  (c_newif),
      .sel     (c_sel),
      .off     (c_off)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q    <= 1'b0;
         kind_q    <= RK_FAULT;
         priv_q    <= 1'b0;
         if_q      <= 1'b0;
         cpl_q     <= 2'd0;
         cur_q     <= '0;
         next_q    <= '0;
         vec_q     <= '0;
         gp        <= 1'b0;
         vec_out   <= '0;
         hnd_sel   <= '0;
         hnd_off   <= '0;
         gate_trap <= 1'b0;
         new_if    <= 1'b0;
         ret_addr  <= '0;
         ret_valid <= 1'b0;
      end else begin
         done_q <= f_fin;
         if (accept) begin
            kind_q <= pick.kind;
            priv_q <= pick.priv_chk;
            vec_q  <= pick.vec;
            if_q   <= if_flag;
            cpl_q  <= cpl;
            cur_q  <= cur_pc;
            next_q <= next_pc;
         end
         if (f_fin) begin
            if (f_bad || !c_ok) begin
               gp        <= 1'b1;
               vec_out   <= GP_VEC;
               hnd_sel   <= '0;
               hnd_off   <= '0;
               gate_trap <= 1'b0;
               new_if    <= if_q;
               ret_addr  <= cur_q;
               ret_valid <= 1'b1;
            end else begin
               gp        <= 1'b0;
               vec_out   <= vec_q;
               hnd_sel   <= c_sel;
               hnd_off   <= c_off;
               gate_trap <= c_trap;
               new_if    <= c_newif;
               case (kind_q)
                  RK_TRAP: begin
                     ret_addr  <= next_q;
                     ret_valid <= 1'b1;
                  end
                  RK_ABORT: begin
                     ret_addr  <= '0;
                     ret_valid <= 1'b0;
                  end
                  default: begin
                     ret_addr  <= cur_q;
                     ret_valid <= 1'b1;
                  end
               endcase
            end
         end
      end
   end

   // R12
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   intgate_if_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !gp && !gate_trap |-> !new_if);

   // R10
   gp_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && gp |-> (vec_out == GP_VEC) && (hnd_off == '0) && ret_valid);
endmodule

// File: tb/ivd_dispatch_test.sv
module ivd_dispatch_test;
   import ivd_pkg::*;

   localparam int BASE_W = 32;
   localparam int LIMIT_W = 16;
   localparam int PC_W = 32;
   localparam logic [31:0] TBASE = 32'h0001_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [47:0] tbl_reg;
   logic        if_flag;
   logic [1:0]  cpl;
   logic [31:0] cur_pc, next_pc;
   logic        nmi_req, exc_req, swi_req, ovf_req, ovf_flag, ud_req, irq_req;
   logic [1:0]  exc_kind;
   logic [7:0]  exc_vec, swi_vec, irq_vec;
   logic        mem_rd, mem_valid;
   logic [31:0] mem_addr, mem_rdata;
   logic        busy, done, gp, gate_trap, new_if, ret_valid;
   logic [7:0]  vec_out;
   logic [15:0] hnd_sel;
   logic [31:0] hnd_off, ret_addr;

   ivd_dispatch #(.BASE_W(BASE_W), .LIMIT_W(LIMIT_W), .PC_W(PC_W), .LIMIT_CHECK(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .tbl_reg(tbl_reg), .if_flag(if_flag), .cpl(cpl),
      .cur_pc(cur_pc), .next_pc(next_pc), .nmi_req(nmi_req), .exc_req(exc_req),
      .exc_kind(exc_kind), .exc_vec(exc_vec), .swi_req(swi_req), .swi_vec(swi_vec),
      .ovf_req(ovf_req), .ovf_flag(ovf_flag), .ud_req(ud_req), .irq_req(irq_req),
      .irq_vec(irq_vec), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_valid(mem_valid), .busy(busy), .done(done), .gp(gp), .vec_out(vec_out),
      .hnd_sel(hnd_sel), .hnd_off(hnd_off), .gate_trap(gate_trap), .new_if(new_if),
      .ret_addr(ret_addr), .ret_valid(ret_valid)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // descriptor content per vector, fixed by the bench
   function automatic logic [4:0] typ_of(input logic [7:0] v);
      if (v == 8'd50) return 5'b00101;
      if (v == 8'd1 || v == 8'd3 || v == 8'd4 || v == 8'd13 || v == 8'd128) return 5'b01111;
      return 5'b01110;
   endfunction

   function automatic logic [31:0] off_of(input logic [7:0] v);
      return 32'hC000_0000 | {20'd0, v, 4'h0};
   endfunction

   function automatic logic [31:0] dword(input logic [7:0] v, input logic hiw);
      logic [31:0] o;
      logic        p;
      logic [1:0]  d;
      o = off_of(v);
      p = (v != 8'd40);
      d = (v == 8'd3 || v == 8'd4 || v == 8'd128) ? 2'd3 : 2'd0;
      if (hiw) return {o[31:16], p, d, typ_of(v), 8'h00};
      return {v, 8'h08, o[15:0]};
   endfunction

   // memory model: each read answered one cycle late
   int          cyc = 0;
   int          rd_cnt = 0;
   int          last_rd_cyc = 0;
   logic [31:0] rd_log [0:15];
   always @(posedge clk) begin
      logic [31:0] a;
      cyc <= cyc + 1;
      a = mem_addr - TBASE;
      if (!rst_n) begin
         mem_valid <= 1'b0;
         mem_rdata <= '0;
      end else begin
         mem_valid <= mem_rd && !mem_valid;
         mem_rdata <= dword(a[10:3], a[2]);
         if (mem_rd && mem_valid) begin
            rd_log[rd_cnt % 16] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
            last_rd_cyc <= cyc;
         end
      end
   end

   typedef struct packed {
      logic       nmi;
      logic       exc;
      logic [1:0] ek;
      logic [7:0] ev;
      logic       swi;
      logic [7:0] sv;
      logic       ovf;
      logic       of;
      logic       ud;
      logic       irq;
      logic [7:0] iv;
      logic       ifl;
      logic [1:0] cpl;
      logic [1:0] res;   // 0 nothing, 1 dispatch, 2 protection outcome
      logic [7:0] xv;
      logic [1:0] xr;    // 0 cur_pc, 1 next_pc, 2 not valid
   } case_t;

   localparam int NCASE = 20;
   localparam case_t CASES [NCASE] = '{
      '{1'b0,1'b0,2'd0,8'd0,  1'b0,8'd0,   1'b0,1'b0,1'b0, 1'b1,8'd33, 1'b1,2'd0, 2'd1,8'd33, 2'd0}, // R2 R3 external
      '{1'b0,1'b0,2'd0,8'd0,  1'b0,8'd0,   1'b0,1'b0,1'b0, 1'b1,8'd33, 1'b0,2'd0, 2'd0,8'd0,  2'd0}, // R3 masked
      '{1'b1,1'b0,2'd0,8'd0,  1'b0,8'd0,   1'b0,1'b0,1'b0, 1'b1,8'd33, 1'b0,2'd0, 2'd1,8'd2,  2'd0}, // R1 nmi over irq
      '{1'b1,1'b0,2'd0,8'd0,  1'b1,8'd128, 1'b0,1'b0,1'b0, 1'b0,8'd0,  1'b1,2'd3, 2'd1,8'd2,  2'd0}, // R1 nmi over swi
      '{1'b0,1'b0,2'd0,8'd0,  1'b1,8'd128, 1'b0,1'b0,1'b0, 1'b0,8'd0,  1'b1,2'd3, 2'd1,8'd128,2'd1}, // R7 dpl3 ok
      '{1'b0,1'b0,2'd0,8'd0,  1'b1,8'd33,  1'b0,1'b0,1'b0, 1'b0,8'd0,  1'b1,2'd3, 2'd2,8'd13, 2'd0}, // R7 priv fail
      '{1'b0,1'b0,2'd0,8'd0,  1'b1,8'd33,  1'b0,1'b0,1'b0, 1'b0,8'd0,  1'b1,2'd0, 2'd1,8'd33, 2'd1}, // R7 cpl0
      '{1'b0,1'b0,2'd0,8'd0,  1'b0,8'd0,   1'b1,1'b1,1'b0, 1'b0,8'd0,  1'b1,2'd3, 2'd1,8'd4,  2'd1}, // R2 overflow taken
      '{1'b0,1'b0,2'd0,8'd0,  1'b0,8'd0,   1'b1,1'b0,1'b0, 1'b0,8'd0,  1'b1,2'd0, 2'd0,8'd0,  2'd0}, // R2 overflow dropped
      '{1'b0,1'b0,2'd0,8'd0,  1'b0,8'd0,   1'b0,1'b0,1'b1, 1'b0,8'd0,  1'b1,2'd3, 2'd1,8'd6,  2'd0}, // R2 R7 invalid-opcode
      '{1'b0,1'b1,2'd0,8'd14, 1'b0,8'd0,   1'b0,1'b0,1'b0, 1'b1,8'd33, 1'b1,2'd0, 2'd1,8'd14, 2'd0}, // R1 R11 fault exc
      '{1'b0,1'b1,2'd1,8'd1,  1'b0,8'd0,   1'b0,1'b0,1'b0, 1'b0,8'd0,  1'b1,2'd0, 2'd1,8'd1,  2'd1}, // R11 trap exc
      '{1'b0,1'b1,2'd2,8'd8,  1'b0,8'd0,   1'b0,1'b0,1'b0, 1'b0,8'd0,  1'b1,2'd0, 2'd1,8'd8,  2'd2}, // R11 abort
      '{1'b0,1'b0,2'd0,8'd0,  1'b0,8'd0,   1'b0,1'b0,1'b0, 1'b1,8'd40, 1'b1,2'd0, 2'd2,8'd13, 2'd0}, // R6 not present
      '{1'b0,1'b0,2'd0,8'd0,  1'b1,8'd50,  1'b0,1'b0,1'b0, 1'b0,8'd0,  1'b1,2'd0, 2'd2,8'd13, 2'd0}, // R8 bad type
      '{1'b0,1'b0,2'd0,8'd0,  1'b1,8'd3,   1'b0,1'b0,1'b0, 1'b0,8'd0,  1'b0,2'd3, 2'd1,8'd3,  2'd1}, // R3 swi unmasked
      '{1'b0,1'b0,2'd0,8'd0,  1'b0,8'd0,   1'b0,1'b0,1'b1, 1'b1,8'd33, 1'b1,2'd0, 2'd1,8'd6,  2'd0}, // R1 ud over irq
      '{1'b0,1'b0,2'd0,8'd0,  1'b1,8'd13,  1'b0,1'b0,1'b0, 1'b0,8'd0,  1'b1,2'd0, 2'd1,8'd13, 2'd1}, // R8 trap gate
      '{1'b0,1'b1,2'd0,8'd0,  1'b1,8'd128, 1'b1,1'b1,1'b0, 1'b0,8'd0,  1'b1,2'd3, 2'd1,8'd0,  2'd0}, // R1 exc first
      '{1'b0,1'b0,2'd0,8'd0,  1'b1,8'd128, 1'b1,1'b1,1'b1, 1'b0,8'd0,  1'b1,2'd3, 2'd1,8'd128,2'd1}  // R1 swi first
   };

   task automatic clear_reqs();
      nmi_req = 0; exc_req = 0; swi_req = 0; ovf_req = 0; ud_req = 0; irq_req = 0;
   endtask

   task automatic wait_done(output bit got);
      got = 0;
      for (int k = 0; k < 40 && !got; k++) begin
         if (done) got = 1;
         else @(negedge clk);
      end
   endtask

   task automatic run_case(input case_t c, input int idx);
      int  rd0;
      bit  got;
      bit  saw;
      logic [31:0] ea;
      @(negedge clk);
      nmi_req = c.nmi; exc_req = c.exc; exc_kind = c.ek; exc_vec = c.ev;
      swi_req = c.swi; swi_vec = c.sv; ovf_req = c.ovf; ovf_flag = c.of;
      ud_req = c.ud; irq_req = c.irq; irq_vec = c.iv; if_flag = c.ifl; cpl = c.cpl;
      cur_pc = 32'h0040_0000 + 32'(idx * 16);
      next_pc = cur_pc + 32'd3;
      rd0 = rd_cnt;
      @(negedge clk);
      clear_reqs();
      if (c.res == 2'd0) begin
         saw = 0;
         for (int k = 0; k < 4; k++) begin
            if (busy || done) saw = 1;
            @(negedge clk);
         end
         chk(!saw, $sformatf("R2/R3 case %0d no dispatch", idx), 64'(saw), 64'd0);
         return;
      end
      chk(busy, $sformatf("R12 case %0d busy after accept", idx), 64'(busy), 64'd1);
      wait_done(got);
      chk(got, $sformatf("R12 case %0d done seen", idx), 64'(got), 64'd1);
      chk(vec_out == c.xv, $sformatf("R1 R2 case %0d vector", idx), 64'(vec_out), 64'(c.xv));
      chk(gp == (c.res == 2'd2), $sformatf("R6 R7 R10 case %0d gp", idx), 64'(gp), 64'(c.res == 2'd2));
      if (c.res == 2'd1) begin
         chk(hnd_off == off_of(c.xv), $sformatf("R5 case %0d offset", idx), 64'(hnd_off), 64'(off_of(c.xv)));
         chk(hnd_sel == {c.xv, 8'h08}, $sformatf("R5 case %0d selector", idx), 64'(hnd_sel), 64'({c.xv, 8'h08}));
         chk(gate_trap == typ_of(c.xv)[0], $sformatf("R8 case %0d gate kind", idx), 64'(gate_trap), 64'(typ_of(c.xv)[0]));
         chk(new_if == (typ_of(c.xv)[0] ? c.ifl : 1'b0), $sformatf("R8 case %0d new_if", idx),
             64'(new_if), 64'(typ_of(c.xv)[0] ? c.ifl : 1'b0));
         ea = TBASE + {21'd0, c.xv, 3'b000};
         chk(rd_cnt - rd0 == 2, $sformatf("R4 case %0d read count", idx), 64'(rd_cnt - rd0), 64'd2);
         chk(rd_log[rd0 % 16] == ea && rd_log[(rd0 + 1) % 16] == ea + 32'd4,
             $sformatf("R4 case %0d read addresses", idx), 64'(rd_log[rd0 % 16]), 64'(ea));
         chk(cyc == last_rd_cyc + 1, $sformatf("R12 case %0d done timing", idx), 64'(cyc), 64'(last_rd_cyc + 1));
         if (c.xr == 2'd2)
            chk(!ret_valid, $sformatf("R11 case %0d abort", idx), 64'(ret_valid), 64'd0);
         else
            chk(ret_valid && ret_addr == (c.xr == 2'd1 ? next_pc : cur_pc),
                $sformatf("R11 case %0d return", idx), 64'(ret_addr), 64'(c.xr == 2'd1 ? next_pc : cur_pc));
      end else begin
         chk(ret_valid && ret_addr == cur_pc && hnd_off == 32'd0 && new_if == c.ifl,
             $sformatf("R10 case %0d outcome", idx), 64'(ret_addr), 64'(cur_pc));
      end
      @(negedge clk);
      chk(!done, $sformatf("R12 case %0d done one cycle", idx), 64'(done), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      bit got;
      int rd0;
      tbl_reg = {TBASE, 16'h07FF};
      if_flag = 1; cpl = 0; cur_pc = 0; next_pc = 0;
      exc_kind = 0; exc_vec = 0; swi_vec = 0; irq_vec = 0; ovf_flag = 0;
      clear_reqs();
      repeat (3) @(negedge clk);
      // R13 reset state
      chk(!busy && !done && !mem_rd, "R13 during reset", {61'd0, busy, done, mem_rd}, 64'd0);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && !done && !mem_rd, "R13 after reset", {61'd0, busy, done, mem_rd}, 64'd0);

      for (int i = 0; i < NCASE; i++) run_case(CASES[i], i);

      // R9 limit boundary: 32 entries
      tbl_reg = {TBASE, 16'h00FF};
      run_case('{1'b0,1'b0,2'd0,8'd0, 1'b1,8'd31, 1'b0,1'b0,1'b0, 1'b0,8'd0, 1'b1,2'd0, 2'd1,8'd31, 2'd1}, 30);
      rd0 = rd_cnt;
      run_case('{1'b0,1'b0,2'd0,8'd0, 1'b1,8'd32, 1'b0,1'b0,1'b0, 1'b0,8'd0, 1'b1,2'd0, 2'd2,8'd13, 2'd0}, 31);
      chk(rd_cnt == rd0, "R9 no read beyond limit", 64'(rd_cnt - rd0), 64'd0);
      tbl_reg = {TBASE, 16'h07FF};

      // R12 requests while busy are ignored
      @(negedge clk);
      swi_req = 1; swi_vec = 8'd33; cpl = 0; if_flag = 1;
      @(negedge clk);
      clear_reqs();
      irq_req = 1; irq_vec = 8'd34; nmi_req = 1;
      wait_done(got);
      clear_reqs();
      chk(got && vec_out == 8'd33, "R12 busy ignores new requests", 64'(vec_out), 64'd33);
      got = 0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (busy) got = 1;
      end
      chk(!got, "R12 ignored request not queued", 64'(got), 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule